// File: doc/BRIEF.md
# Indirect PCS Register Window

This block is the 16-bit configuration register file of a PCS control block. The host sees it through an 8 KiB window on a simple request bus of valid, write, address and data signals. One word in the window, at byte offset 0x1FE, is a bank-select register. The value held there decides which of four register banks the rest of the window addresses: standard control, standard MII, standard timing-sync or vendor MII. A register's index inside the selected bank is the byte offset divided by two.

Every register holds a fixed default value. A hardware reset loads all of these defaults. Software can also reload them by setting the top bit of the MII control word, and that reload leaves the bank-select register as it was. Any access that cannot be served is rejected and flagged by a one-cycle error pulse that comes with the response: a select code that matches no bank, an index past the end of the chosen bank, or an odd byte address. A rejected read returns zero and a rejected write changes nothing.

Top module: `pcs_reg_window`

## Requirements
- R1: A hardware reset (rstN low) clears the bank-select register to 0x0000, loads every bank register with its default value and holds rspValid, rspErr and rspRdata at zero.
- R2: The word at byte address 0x1FE is the bank-select register. It is written and read at that address whatever value it holds, and such an access never raises rspErr.
- R3: Select code 0x1E00 maps the window onto the control bank (9 registers), 0x1F00 onto the MII bank (16), 0x1F07 onto the timing-sync bank (17) and 0x1F80 onto the vendor bank (227). Byte address A reaches register A/2 of the selected bank.
- R4: While the select register holds any other code, a read of an address other than 0x1FE returns zero, a write is discarded and rspErr is set.
- R5: A register index equal to or greater than the size of the selected bank reads as zero, ignores writes and sets rspErr.
- R6: A request with address bit 0 set is rejected. A read returns zero, a write changes no register, and rspErr is set.
- R7: Every request gives exactly one response cycle. In the cycle after the request, rspValid is 1, rspErr is valid and rspRdata holds the read data. A write response carries zero data.
- R8: A write to MII register 0 with data bit 15 set reloads every register of all four banks with its default, so MII register 0 then reads 0x1140. The same write with bit 15 clear only stores the value.
- R9: The reload described in R8 leaves the bank-select register unchanged.
- R10: Default values, all others zero. Control bank: reg 4 = 0x699E, reg 8 = 0x8000. MII bank: reg 0 = 0x1140, reg 1 = 0x0109, reg 2 = 0x699E, reg 3 = 0xCED0, reg 4 = 0x0020, reg 15 = 0xC000. Timing-sync bank: reg 8 = 0x0003, reg 9 = 0x0038, reg 11 = 0x0038, reg 13 = 0x0058, reg 15 = 0x0048. Vendor bank: reg 0 = 0x2400, reg 2 = 0x000A, reg 6 = 0x899C, reg 16 = 0x0010, reg 56 = 0x000A, reg 58 = 0x007F, reg 61 = 0x0001, reg 88 = 0x0100, reg 89 = 0x1100, reg 93 = 0x000E, reg 120 = 0x0100, reg 121 = 0x0032, reg 136 = 0x0001, reg 152 = 0x0019.
- R11: Every bank register is fully writable. Registers with the same index in different banks are independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 13 | Byte address inside the 8 KiB window |
| reqWdata | input | 16 | Write data |
| rspValid | output | 1 | Response cycle, one cycle after a request |
| rspRdata | output | 16 | Read data (zero for writes and rejected reads) |
| rspErr | output | 1 | Request was rejected |

## Verification
Each bank is swept at every index with its defaults, then with a written pattern that differs per bank and per index. The pattern shows whether bank offsets alias one another and whether the index is decoded correctly. Reads at the first index past each bank, an unmatched select code and odd addresses check the rejection paths. Follow-up reads of neighbouring registers show whether any rejected write leaked into storage. A reload with bit 15 set is compared against one with bit 15 clear, and a second hardware reset after the registers have been written tells the reload paths apart from the power-on state.

// File: rtl/pcs_reg_pkg.sv
package pcs_reg_pkg;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 16;
  localparam int IDX_W = ADDR_W - 1;
  localparam int SOFT_BIT = 15;

  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(13'h1FE);
  localparam logic [DATA_W-1:0] CODE_CTL = 16'h1E00;
  localparam logic [DATA_W-1:0] CODE_MII = 16'h1F00;
  localparam logic [DATA_W-1:0] CODE_TSY = 16'h1F07;
  localparam logic [DATA_W-1:0] CODE_VND = 16'h1F80;

  typedef enum logic [1:0] {
    BANK_CTL = 2'd0,
    BANK_MII = 2'd1,
    BANK_TSY = 2'd2,
    BANK_VND = 2'd3
  } bank_e;

  // Strobes from the decode stage to the storage stage.
  typedef struct packed {
    logic             selWr;
    logic             selRd;
    logic             regWr;
    logic             regRd;
    logic             softLoad;
    logic             accErr;
    logic [IDX_W-1:0] flatIdx;
  } strobe_t;

  function automatic logic [DATA_W-1:0] bankDefault(bank_e bank, int unsigned idx);
    logic [DATA_W-1:0] v;
    v = '0;
    case (bank)
      BANK_CTL: case (idx)
        4: v = 16'h699E;
        8: v = 16'h8000;
        default: v = '0;
      endcase
      BANK_MII: case (idx)
        0: v = 16'h1140;
        1: v = 16'h0109;
        2: v = 16'h699E;
        3: v = 16'hCED0;
        4: v = 16'h0020;
        15: v = 16'hC000;
        default: v = '0;
      endcase
      BANK_TSY: case (idx)
        8: v = 16'h0003;
        9: v = 16'h0038;
        11: v = 16'h0038;
        13: v = 16'h0058;
        15: v = 16'h0048;
        default: v = '0;
      endcase
      default: case (idx)
        0: v = 16'h2400;
        2: v = 16'h000A;
        6: v = 16'h899C;
        16: v = 16'h0010;
        56: v = 16'h000A;
        58: v = 16'h007F;
        61: v = 16'h0001;
        88: v = 16'h0100;
        89: v = 16'h1100;
        93: v = 16'h000E;
        120: v = 16'h0100;
        121: v = 16'h0032;
        136: v = 16'h0001;
        152: v = 16'h0019;
        default: v = '0;
      endcase
    endcase
    return v;
  endfunction
endpackage

// File: rtl/pcs_reg_ctrl.sv
module pcs_reg_ctrl
  import pcs_reg_pkg::*;
#(
  parameter int CTL_N = 9,
  parameter int MII_N = 16,
  parameter int TSY_N = 17,
  parameter int VND_N = 227
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              softBit,
  input  logic [DATA_W-1:0] baseReg,
  output strobe_t           strb
);
  localparam int OFF_MII = CTL_N;
  localparam int OFF_TSY = OFF_MII + MII_N;
  localparam int OFF_VND = OFF_TSY + TSY_N;

  logic             aligned;
  logic             atSel;
  logic             bankOk;
  logic             inRange;
  logic             regHit;
  bank_e            bank;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] bankSize;
  logic [IDX_W-1:0] bankOff;

  always_comb begin
    aligned  = ~reqAddr[0];
    atSel    = (reqAddr == SEL_ADDR);
    idx      = reqAddr[ADDR_W-1:1];
    bankOk   = 1'b1;
    bank     = BANK_CTL;
    bankSize = '0;
    bankOff  = '0;
    case (baseReg)
      CODE_CTL: begin bank = BANK_CTL; bankSize = IDX_W'(CTL_N); bankOff = '0; end
      CODE_MII: begin bank = BANK_MII; bankSize = IDX_W'(MII_N); bankOff = IDX_W'(OFF_MII); end
      CODE_TSY: begin bank = BANK_TSY; bankSize = IDX_W'(TSY_N); bankOff = IDX_W'(OFF_TSY); end
      CODE_VND: begin bank = BANK_VND; bankSize = IDX_W'(VND_N); bankOff = IDX_W'(OFF_VND); end
      default:  bankOk = 1'b0;
    endcase
    inRange = (idx < bankSize);
    regHit  = reqValid & aligned & ~atSel & bankOk & inRange;

    strb.selWr    = reqValid & aligned & atSel & reqWrite;
    strb.selRd    = reqValid & aligned & atSel & ~reqWrite;
    strb.regWr    = regHit & reqWrite;
    strb.regRd    = regHit & ~reqWrite;
    strb.softLoad = regHit & reqWrite & (bank == BANK_MII) & (idx == '0) & softBit;
    strb.accErr   = reqValid & ~(aligned & (atSel | (bankOk & inRange)));
    strb.flatIdx  = bankOff + idx;
  end
endmodule

// File: rtl/pcs_reg_datapath.sv
module pcs_reg_datapath
  import pcs_reg_pkg::*;
#(
  parameter int CTL_N = 9,
  parameter int MII_N = 16,
  parameter int TSY_N = 17,
  parameter int VND_N = 227
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [DATA_W-1:0] reqWdata,
  input  strobe_t           strb,
  output logic [DATA_W-1:0] baseReg,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr
);
  localparam int OFF_MII = CTL_N;
  localparam int OFF_TSY = OFF_MII + MII_N;
  localparam int OFF_VND = OFF_TSY + TSY_N;
  localparam int TOTAL   = OFF_VND + VND_N;
  localparam int FLAT_W  = $clog2(TOTAL);

  function automatic logic [DATA_W-1:0] resetValue(int unsigned g);
    if (g < OFF_MII) return bankDefault(BANK_CTL, g);
    else if (g < OFF_TSY) return bankDefault(BANK_MII, g - OFF_MII);
    else if (g < OFF_VND) return bankDefault(BANK_TSY, g - OFF_TSY);
    else return bankDefault(BANK_VND, g - OFF_VND);
  endfunction

  logic [DATA_W-1:0] regs [TOTAL];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) baseReg <= '0;
    else if (strb.selWr) baseReg <= reqWdata;
  end

  for (genvar g = 0; g < TOTAL; g++) begin : gReg
    localparam logic [DATA_W-1:0] RST_VAL = resetValue(g);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= RST_VAL;
      else if (strb.softLoad) q <= RST_VAL;
      else if (strb.regWr && strb.flatIdx == IDX_W'(g)) q <= reqWdata;
    end
    assign regs[g] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= strb.accErr;
      if (strb.selRd) rspRdata <= baseReg;
      else if (strb.regRd) rspRdata <= regs[FLAT_W'(strb.flatIdx)];
      else rspRdata <= '0;
    end
  end
endmodule

// File: rtl/pcs_reg_window.sv
module pcs_reg_window
  import pcs_reg_pkg::*;
#(
  parameter int CTL_N = 9,
  parameter int MII_N = 16,
  parameter int TSY_N = 17,
  parameter int VND_N = 227
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr
);
  strobe_t           strb;
  logic [DATA_W-1:0] baseReg;

  pcs_reg_ctrl #(.CTL_N(CTL_N), .MII_N(MII_N), .TSY_N(TSY_N), .VND_N(VND_N)) uCtrl (
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .softBit (reqWdata[SOFT_BIT]),
    .baseReg (baseReg),
    .strb    (strb)
  );

  pcs_reg_datapath #(.CTL_N(CTL_N), .MII_N(MII_N), .TSY_N(TSY_N), .VND_N(VND_N)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWdata(reqWdata),
    .strb    (strb),
    .baseReg (baseReg),
    .rspValid(rspValid),
    .rspRdata(rspRdata),
    .rspErr  (rspErr)
  );
endmodule

// File: rtl/pcs_reg_window_chk.sv
module pcs_reg_window_chk
  import pcs_reg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqWdata,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspRdata,
  input logic              rspErr,
  input logic [DATA_W-1:0] baseReg,
  input strobe_t           strb
);
  logic codeKnown;
  assign codeKnown = (baseReg == CODE_CTL) || (baseReg == CODE_MII) ||
                     (baseReg == CODE_TSY) || (baseReg == CODE_VND);

  assert_rsp_follows_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_no_idle_rsp_R7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspErr && rspRdata == '0));

  assert_odd_addr_rejected_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[0]) |=> (rspErr && rspRdata == '0));

  assert_sel_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqAddr == SEL_ADDR) |=> (baseReg == $past(reqWdata)));

  assert_sel_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqAddr == SEL_ADDR) |=> (rspRdata == $past(baseReg) && !rspErr));

  assert_bad_code_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqAddr != SEL_ADDR && !codeKnown) |=> (rspErr && rspRdata == '0));

  assert_reload_keeps_sel_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.softLoad |=> $stable(baseReg));
endmodule

bind pcs_reg_window pcs_reg_window_chk chk (.*);

// File: tb/pcs_reg_window_test.sv
module pcs_reg_window_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [12:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        rspValid;
  logic [15:0] rspRdata;
  logic        rspErr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int          bankSize [4] = '{9, 16, 17, 227};
  logic [15:0] bankCode [4] = '{16'h1E00, 16'h1F00, 16'h1F07, 16'h1F80};

  always #5 clk = ~clk;

  pcs_reg_window uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr)
  );

  function automatic logic [15:0] expDef(int b, int i);
    logic [15:0] v = '0;
    if (b == 0) begin
      if (i == 4) v = 16'h699E; else if (i == 8) v = 16'h8000;
    end else if (b == 1) begin
      case (i)
        0: v = 16'h1140; 1: v = 16'h0109; 2: v = 16'h699E;
        3: v = 16'hCED0; 4: v = 16'h0020; 15: v = 16'hC000;
        default: v = '0;
      endcase
    end else if (b == 2) begin
      case (i)
        8: v = 16'h0003; 9: v = 16'h0038; 11: v = 16'h0038;
        13: v = 16'h0058; 15: v = 16'h0048;
        default: v = '0;
      endcase
    end else begin
      case (i)
        0: v = 16'h2400; 2: v = 16'h000A; 6: v = 16'h899C; 16: v = 16'h0010;
        56: v = 16'h000A; 58: v = 16'h007F; 61: v = 16'h0001; 88: v = 16'h0100;
        89: v = 16'h1100; 93: v = 16'h000E; 120: v = 16'h0100; 121: v = 16'h0032;
        136: v = 16'h0001; 152: v = 16'h0019;
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  function automatic logic [15:0] pat(int b, int i);
    logic [15:0] v;
    v = 16'(b * 4096 + i * 263) ^ 16'h0A5A;
    v[15] = 1'b0;
    return v;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [12:0] addr, input logic [15:0] data,
                        output logic [15:0] rd, output logic err, output logic vld);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = data;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    rd = rspRdata; err = rspErr; vld = rspValid;
  endtask

  task automatic wr(input string req, input logic [12:0] addr, input logic [15:0] data,
                    input logic expErr);
    logic [15:0] rd; logic err; logic vld;
    access(1'b1, addr, data, rd, err, vld);
    check({req, " write rspValid"}, 16'(vld), 16'd1);
    check({req, " write rspErr"}, 16'(err), 16'(expErr));
    check({req, " R7 write data zero"}, rd, 16'h0000);
  endtask

  task automatic rdChk(input string req, input logic [12:0] addr, input logic [15:0] exp,
                       input logic expErr);
    logic [15:0] rd; logic err; logic vld;
    access(1'b0, addr, 16'h0, rd, err, vld);
    check({req, " R7 read rspValid"}, 16'(vld), 16'd1);
    check({req, " read rspErr"}, 16'(err), 16'(expErr));
    check({req, " read data"}, rd, exp);
  endtask

  task automatic hardReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 rspValid in reset", 16'(rspValid), 16'd0);
    check("R1 rspErr in reset", 16'(rspErr), 16'd0);
    check("R1 rspRdata in reset", rspRdata, 16'h0000);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    hardReset();
    // R1/R2: select register starts at zero; with no valid code, banks are unreachable (R4).
    rdChk("R1 R2 select after reset", 13'h1FE, 16'h0000, 1'b0);
    rdChk("R4 read with zero code", 13'h000, 16'h0000, 1'b1);

    // R3/R10/R5: default sweep of every bank and out-of-range probes.
    for (int b = 0; b < 4; b++) begin
      wr("R2 select write", 13'h1FE, bankCode[b], 1'b0);
      rdChk("R2 select readback", 13'h1FE, bankCode[b], 1'b0);
      for (int i = 0; i < bankSize[b]; i++)
        rdChk("R10 R3 default", 13'(i * 2), expDef(b, i), 1'b0);
      rdChk("R5 first index past bank", 13'(bankSize[b] * 2), 16'h0000, 1'b1);
      rdChk("R5 far index", 13'h1FC, 16'h0000, 1'b1);
      wr("R5 write past bank", 13'(bankSize[b] * 2), 16'h7777, 1'b1);
    end

    // R11: per-bank pattern, then readback of all banks.
    for (int b = 0; b < 4; b++) begin
      wr("R2 select write", 13'h1FE, bankCode[b], 1'b0);
      for (int i = 0; i < bankSize[b]; i++)
        wr("R11 pattern", 13'(i * 2), pat(b, i), 1'b0);
    end
    for (int b = 0; b < 4; b++) begin
      wr("R2 select write", 13'h1FE, bankCode[b], 1'b0);
      for (int i = 0; i < bankSize[b]; i++)
        rdChk("R11 R5 pattern readback", 13'(i * 2), pat(b, i), 1'b0);
    end

    // R4: unknown code discards writes.
    wr("R2 select write", 13'h1FE, 16'h1F01, 1'b0);
    wr("R4 write with unknown code", 13'h000, 16'h1234, 1'b1);
    rdChk("R4 read with unknown code", 13'h000, 16'h0000, 1'b1);
    rdChk("R2 select readback unknown", 13'h1FE, 16'h1F01, 1'b0);
    wr("R2 select write", 13'h1FE, 16'h1F00, 1'b0);
    rdChk("R4 MII reg0 untouched", 13'h000, pat(1, 0), 1'b0);

    // R6: odd addresses rejected, storage untouched.
    wr("R6 odd write", 13'h003, 16'hFFFF, 1'b1);
    wr("R6 odd write reg0", 13'h001, 16'hFFFF, 1'b1);
    rdChk("R6 odd read", 13'h001, 16'h0000, 1'b1);
    rdChk("R6 MII reg1 untouched", 13'h002, pat(1, 1), 1'b0);
    rdChk("R6 MII reg0 untouched", 13'h000, pat(1, 0), 1'b0);

    // R8/R9: soft reload.
    wr("R8 reload write", 13'h000, 16'h9234, 1'b0);
    rdChk("R9 select kept", 13'h1FE, 16'h1F00, 1'b0);
    rdChk("R8 MII reg0 reads default", 13'h000, 16'h1140, 1'b0);
    for (int b = 0; b < 4; b++) begin
      wr("R2 select write", 13'h1FE, bankCode[b], 1'b0);
      for (int i = 0; i < bankSize[b]; i++)
        rdChk("R8 R10 reloaded default", 13'(i * 2), expDef(b, i), 1'b0);
    end

    // R8: bit 15 clear just stores.
    wr("R11 vendor write", 13'h00A, 16'h5555, 1'b0);
    wr("R2 select write", 13'h1FE, 16'h1F00, 1'b0);
    wr("R8 plain MII reg0 write", 13'h000, 16'h0140, 1'b0);
    rdChk("R8 plain value stored", 13'h000, 16'h0140, 1'b0);
    wr("R2 select write", 13'h1FE, 16'h1F80, 1'b0);
    rdChk("R8 no reload on bit15 clear", 13'h00A, 16'h5555, 1'b0);

    // R1: hardware reset after writes.
    hardReset();
    rdChk("R1 select cleared", 13'h1FE, 16'h0000, 1'b0);
    wr("R2 select write", 13'h1FE, 16'h1F80, 1'b0);
    rdChk("R1 vendor reg5 default", 13'h00A, 16'h0000, 1'b0);
    wr("R2 select write", 13'h1FE, 16'h1F00, 1'b0);
    rdChk("R1 MII reg0 default", 13'h000, 16'h1140, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule